// File: doc/BRIEF.md
# Escalating Multi-Stage Watchdog

This block is a watchdog timer that climbs through four timeout stages, one after another. Each stage has its own timeout, counted in clock ticks, and its own action. When a stage runs out, the block takes that stage's action and moves on to the next stage. The possible actions are: nothing, a level interrupt, a CPU reset pulse, a system reset pulse, or a full reset pulse that also resets the always-on domain. Software keeps the block quiet by feeding it. A feed sends the timer back to the first stage with a cleared count.

Configuration uses a small register interface. Every configuration write is refused until a 32-bit key has been written to the lock register. The interrupt clear is the one exception. Reset outputs are pulses. Their width comes from a 3-bit length code, set separately for the CPU reset and for the system resets. The block turns the code into a cycle count using the clock period given as a parameter.

Top module: `wdog_escalator`

## Requirements
- R1: After reset the lock is engaged, the timer is disabled and every stage action is 0 (off). `irq`, `cpu_rst`, `sys_rst` and `aon_rst` are low, and registers 1, 2 and 4..7 read 0.
- R2: Writing UNLOCK_KEY (default 32'h5A1C_E0F3) to address 0 clears the lock. Writing any other value to address 0 sets it. Bit 0 of address 0 reads 1 while locked.
- R3: While locked, writes to address 1 (control), address 2 (actions) and addresses 4..7 (timeouts) leave those registers unchanged.
- R4: Address 4+n holds the timeout T of stage n. Once stage n is entered with the timer enabled, it expires on the (T+1)-th clock cycle, so T=0 expires on the very next edge.
- R5: Address 2 bits [3n+2:3n] select the action of stage n: 0 off, 1 interrupt, 2 CPU reset, 3 system reset, 4 full reset (`sys_rst` and `aon_rst` together). Codes 5..7 act as off. A stage whose action is off never expires.
- R6: After an expiry the timer moves to the next stage. After stage 3 expires, the done flag is set and nothing more fires. If the next stage's action is off, the timer waits there. Address 3 reads {done[3], stage[2:1], irq[0]}.
- R7: A `feed` cycle while enabled returns the timer to stage 0 with the count at zero and clears done. A feed takes priority over an expiry in the same cycle.
- R8: Address 1 bit 0 enables the timer. Clearing it stops counting and returns the timer to stage 0, so no further actions fire.
- R9: Address 1 bits [4:2] set the CPU pulse length code, and bits [7:5] set the code used by both system resets. The code means 100, 200, 300, 400, 500, 800, 1600 or 3200 ns, for codes 0 to 7. The pulse rises on the cycle after the expiry edge and stays high for ceil(ns/TICK_NS) cycles, with a minimum of one.
- R10: `irq` is a level. An interrupt-stage expiry sets it. Writing 1 to bit 0 of address 3 clears it, even while locked. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feed | input | 1 | Restart the timer at stage 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Watchdog interrupt level |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |
| aon_rst | output | 1 | Always-on domain reset pulse |

## Verification
The bench builds the block with TICK_NS=100, which makes the eight length codes equal 1, 2, 3, 4, 5, 8, 16 and 32 cycles. Every pulse width, including the longest, then fits in a 60-cycle observation window, and each width can be compared exactly against the code. Timeouts are kept to a few dozen ticks or fewer. This lets the bench watch stage-by-stage escalation, the end after stage 3, and a feed that lands just before an expiry, all cycle by cycle.

// File: rtl/wdog_pkg.sv
// Shared definitions for the escalating watchdog: stage count, register
// addresses, action codes and the pulse-length lookup in nanoseconds.
package wdog_pkg;

    localparam int NUM_STAGES = 4;
    localparam int STG_W      = $clog2(NUM_STAGES);
    localparam int ADDR_W     = 3;
    localparam int ACT_W      = 3;

    localparam logic [ADDR_W-1:0] A_LOCK   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_ACTION = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE = 3'd0,
        ACT_IRQ  = 3'd1,
        ACT_CPU  = 3'd2,
        ACT_SYS  = 3'd3,
        ACT_FULL = 3'd4
    } wd_act_e;

    // Nominal pulse length for a 3-bit length code.
    function automatic int unsigned pulse_ns(input logic [2:0] code);
        case (code)
            3'd0:    return 100;
            3'd1:    return 200;
            3'd2:    return 300;
            3'd3:    return 400;
            3'd4:    return 500;
            3'd5:    return 800;
            3'd6:    return 1600;
            default: return 3200;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
// Configuration registers of the watchdog.
// Holds the lock, the enable, the two pulse-length codes, the per-stage actions
// and timeouts, and the interrupt level. Writes other than the interrupt
// clear need the lock to be open. Read data is combinational on the address.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          TMO_W      = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h5A1C_E0F3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    input  logic                          irq_set,
    input  logic [STG_W-1:0]              stage_i,
    input  logic                          done_i,
    output logic                          en_o,
    output logic [2:0]                    cpu_code_o,
    output logic [2:0]                    sys_code_o,
    output logic [NUM_STAGES*ACT_W-1:0]   act_o,
    output logic [NUM_STAGES-1:0][TMO_W-1:0] tmo_o,
    output logic                          irq_o
);

    logic locked_q;
    logic wr_open;

    assign wr_open = we && !locked_q;

    // Lock register: opened only by the exact key.
    always_ff @(posedge clk) begin
        if (!rst_n)                    locked_q <= 1'b1;
        else if (we && addr == A_LOCK) locked_q <= (wdata != UNLOCK_KEY);
    end

    // Control register: enable and the two pulse-length codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            cpu_code_o <= 3'd0;
            sys_code_o <= 3'd0;
        end else if (wr_open && addr == A_CTRL) begin
            en_o       <= wdata[0];
            cpu_code_o <= wdata[4:2];
            sys_code_o <= wdata[7:5];
        end
    end

    // Action register: three bits per stage.
    always_ff @(posedge clk) begin
        if (!rst_n)                          act_o <= '0;
        else if (wr_open && addr == A_ACTION) act_o <= wdata[NUM_STAGES*ACT_W-1:0];
    end

    // One timeout register per stage at address 4 + stage.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_tmo
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmo_o[s] <= '0;
            else if (wr_open && addr[2] && addr[STG_W-1:0] == STG_W'(s))
                tmo_o[s] <= wdata[TMO_W-1:0];
        end
    end

    // Interrupt level: a set wins over a write-one clear; the clear ignores the lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    irq_o <= 1'b0;
        else if (irq_set)                              irq_o <= 1'b1;
        else if (we && addr == A_STATUS && wdata[0])   irq_o <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr[2]) begin
            rdata[TMO_W-1:0] = tmo_o[addr[STG_W-1:0]];
        end else begin
            case (addr)
                A_LOCK:   rdata[0] = locked_q;
                A_CTRL:   rdata[7:0] = {sys_code_o, cpu_code_o, 1'b0, en_o};
                A_ACTION: rdata[NUM_STAGES*ACT_W-1:0] = act_o;
                default:  rdata[3:0] = {done_i, stage_i, irq_o};
            endcase
        end
    end

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && we && addr == A_CTRL) |=> $stable({en_o, cpu_code_o, sys_code_o}))
        else $error("control changed while locked");

    assert_key_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_LOCK && wdata == UNLOCK_KEY) |=> !locked_q)
        else $error("key did not unlock");

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq_o)
        else $error("interrupt not raised");

endmodule

// File: rtl/wdog_stager.sv
// Stage sequencer and tick counter.
// Counts clock ticks in the current stage and, at expiry, emits a one-cycle
// strobe for the stage's action, then moves on. Assumes the action codes of
// wdog_pkg; codes other than 1..4 are treated as off and never expire.
module wdog_stager
    import wdog_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          feed,
    input  logic [NUM_STAGES*ACT_W-1:0]   act,
    input  logic [NUM_STAGES-1:0][TMO_W-1:0] tmo,
    output logic                          fire_irq,
    output logic                          fire_cpu,
    output logic                          fire_sys,
    output logic                          fire_full,
    output logic [STG_W-1:0]              stage_o,
    output logic                          done_o
);

    logic [TMO_W-1:0] cnt_q;
    logic [STG_W-1:0] stage_q;
    logic             done_q;
    logic [ACT_W-1:0] cur_act;
    logic             live;
    logic             expire;

    assign cur_act = act[stage_q*ACT_W +: ACT_W];

    // Decide whether the current stage counts and whether it expires this cycle.
    always_comb begin
        live   = en && !done_q && (cur_act inside {ACT_IRQ, ACT_CPU, ACT_SYS, ACT_FULL});
        expire = live && !feed && (cnt_q >= tmo[stage_q]);
    end

    // Decode the action of an expiring stage into strobes.
    always_comb begin
        fire_irq  = expire && (cur_act == ACT_IRQ);
        fire_cpu  = expire && (cur_act == ACT_CPU);
        fire_sys  = expire && (cur_act == ACT_SYS);
        fire_full = expire && (cur_act == ACT_FULL);
    end

    // Advance the count and stage; feed or disable restarts at stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || feed) begin
            cnt_q   <= '0;
            stage_q <= '0;
            done_q  <= 1'b0;
        end else if (expire) begin
            cnt_q <= '0;
            if (stage_q == STG_W'(NUM_STAGES - 1)) done_q  <= 1'b1;
            else                                   stage_q <= stage_q + 1'b1;
        end else if (live) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stage_o = stage_q;
    assign done_o  = done_q;

    assert_feed_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && en) |=> (stage_q == '0 && cnt_q == '0 && !done_q))
        else $error("feed did not restart the timer");

    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !feed && !fire_irq && !fire_cpu && !fire_sys && !fire_full && $past(en))
            |=> $stable(stage_q))
        else $error("stage moved without an expiry");

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(fire_irq || fire_cpu || fire_sys || fire_full))
        else $error("action fired while disabled");

endmodule

// File: rtl/wdog_pulse.sv
// Reset pulse stretcher.
// A trigger loads a down-counter with the number of clock ticks for the
// length code, given the clock period TICK_NS. The output is high while the
// counter is non-zero. A new trigger during a pulse reloads it.
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int TICK_NS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [2:0] code,
    output logic       pulse_o
);

    localparam int MAX_TICKS = (3200 + TICK_NS - 1) / TICK_NS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 2);

    logic [CNT_W-1:0] cnt_q;

    // Ticks for a code, rounded up, at least one.
    function automatic logic [CNT_W-1:0] ticks_for(input logic [2:0] c);
        int unsigned t;
        t = (pulse_ns(c) + TICK_NS - 1) / TICK_NS;
        if (t == 0) t = 1;
        return CNT_W'(t);
    endfunction

    // Load on trigger, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (trig)       cnt_q <= ticks_for(code);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse_o)
        else $error("pulse did not start");

    assert_pulse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !pulse_o) |=> !pulse_o)
        else $error("pulse rose without trigger");

endmodule

// File: rtl/wdog_escalator.sv
// Escalating four-stage watchdog, top level.
// Connects the register file, the stage sequencer and three pulse
// stretchers (CPU, system, always-on). A full reset drives both the system
// and always-on pulses using the system length code.
module wdog_escalator
    import wdog_pkg::*;
#(
    parameter int          TMO_W      = 32,
    parameter int          TICK_NS    = 25,
    parameter logic [31:0] UNLOCK_KEY = 32'h5A1C_E0F3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        feed,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq,
    output logic        cpu_rst,
    output logic        sys_rst,
    output logic        aon_rst
);

    localparam int NCH = 3;

    logic                             en;
    logic [2:0]                       cpu_code, sys_code;
    logic [NUM_STAGES*ACT_W-1:0]      act;
    logic [NUM_STAGES-1:0][TMO_W-1:0] tmo;
    logic                             f_irq, f_cpu, f_sys, f_full;
    logic [STG_W-1:0]                 stage;
    logic                             done;
    logic [NCH-1:0]                   ch_trig;
    logic [NCH-1:0][2:0]              ch_code;
    logic [NCH-1:0]                   ch_out;

    wdog_regs #(.TMO_W(TMO_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .irq_set(f_irq), .stage_i(stage), .done_i(done),
        .en_o(en), .cpu_code_o(cpu_code), .sys_code_o(sys_code), .act_o(act),
        .tmo_o(tmo), .irq_o(irq)
    );

    wdog_stager #(.TMO_W(TMO_W)) u_stager (
        .clk(clk), .rst_n(rst_n), .en(en), .feed(feed), .act(act), .tmo(tmo),
        .fire_irq(f_irq), .fire_cpu(f_cpu), .fire_sys(f_sys), .fire_full(f_full),
        .stage_o(stage), .done_o(done)
    );

    // Channel map: 0 CPU, 1 system, 2 always-on.
    assign ch_trig = {f_full, f_sys | f_full, f_cpu};
    assign ch_code = {sys_code, sys_code, cpu_code};

    for (genvar c = 0; c < NCH; c++) begin : g_pulse
        wdog_pulse #(.TICK_NS(TICK_NS)) u_pulse (
            .clk(clk), .rst_n(rst_n), .trig(ch_trig[c]), .code(ch_code[c]),
            .pulse_o(ch_out[c])
        );
    end

    assign cpu_rst = ch_out[0];
    assign sys_rst = ch_out[1];
    assign aon_rst = ch_out[2];

endmodule

// File: tb/tb_wdog_escalator.sv
module tb_wdog_escalator;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] KEY        = 32'h5A1C_E0F3;
    localparam int          NV         = 6;
    localparam int          WIN        = 60;

    // Vector table: stage-0 timeout, action, cpu code, sys code, expected rise sample, expected width.
    localparam logic [31:0] V_TMO  [NV] = '{32'd5, 32'd0, 32'd10, 32'd2, 32'd7, 32'd1};
    localparam logic [2:0]  V_ACT  [NV] = '{3'd2, 3'd3, 3'd4, 3'd1, 3'd2, 3'd3};
    localparam logic [2:0]  V_CPU  [NV] = '{3'd2, 3'd0, 3'd0, 3'd0, 3'd6, 3'd0};
    localparam logic [2:0]  V_SYS  [NV] = '{3'd0, 3'd5, 3'd7, 3'd0, 3'd0, 3'd0};
    localparam int          V_RISE [NV] = '{6, 1, 11, 3, 8, 2};
    localparam int          V_WID  [NV] = '{3, 8, 32, 58, 16, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feed = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        irq, cpu_rst, sys_rst, aon_rst;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_escalator #(.TMO_W(32), .TICK_NS(100), .UNLOCK_KEY(KEY)) dut (
        .clk(clk), .rst_n(rst_n), .feed(feed), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .cpu_rst(cpu_rst),
        .sys_rst(sys_rst), .aon_rst(aon_rst)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_feed();
        feed = 1'b1;
        @(negedge clk);
        feed = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int rise, n_irq, n_cpu, n_sys, n_aon, prim;
        int e_irq, e_cpu, e_sys, e_aon;

        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "irq", {31'd0, irq}, 0);
        chk("R1", "cpu_rst", {31'd0, cpu_rst}, 0);
        chk("R1", "sys_rst", {31'd0, sys_rst}, 0);
        chk("R1", "aon_rst", {31'd0, aon_rst}, 0);
        rd(3'd0, r); chk("R1", "lock bit", r, 1);
        rd(3'd1, r); chk("R1", "ctrl", r, 0);
        rd(3'd2, r); chk("R1", "actions", r, 0);
        rd(3'd4, r); chk("R1", "timeout0", r, 0);

        // R3: writes ignored while locked
        wr(3'd2, 32'd1);
        wr(3'd4, 32'd77);
        wr(3'd1, 32'h1);
        rd(3'd1, r); chk("R3", "ctrl locked", r, 0);
        rd(3'd2, r); chk("R3", "actions locked", r, 0);
        rd(3'd4, r); chk("R3", "timeout locked", r, 0);
        wait_cyc(5);
        chk("R3", "no irq while locked", {31'd0, irq}, 0);

        // R2: key unlocks, other value locks
        wr(3'd0, KEY);
        rd(3'd0, r); chk("R2", "unlocked", r, 0);
        wr(3'd0, 32'h1234);
        rd(3'd0, r); chk("R2", "relocked", r, 1);
        wr(3'd0, KEY);
        wr(3'd6, 32'd99);
        rd(3'd6, r); chk("R2", "timeout2 written", r, 99);
        wr(3'd6, 32'd0);

        // Vector table: one stage, one action, measured rise and width (R4, R5, R9, R10)
        for (int v = 0; v < NV; v++) begin
            wr(3'd2, {29'd0, V_ACT[v]});
            wr(3'd4, V_TMO[v]);
            wr(3'd1, {24'd0, V_SYS[v], V_CPU[v], 2'b01});
            rise = 0; n_irq = 0; n_cpu = 0; n_sys = 0; n_aon = 0;
            for (int k = 1; k <= WIN; k++) begin
                @(negedge clk);
                case (V_ACT[v])
                    3'd1:    prim = irq;
                    3'd2:    prim = cpu_rst;
                    default: prim = sys_rst;
                endcase
                if (prim != 0 && rise == 0) rise = k;
                n_irq += irq; n_cpu += cpu_rst; n_sys += sys_rst; n_aon += aon_rst;
            end
            e_irq = (V_ACT[v] == 3'd1) ? V_WID[v] : 0;
            e_cpu = (V_ACT[v] == 3'd2) ? V_WID[v] : 0;
            e_sys = (V_ACT[v] >= 3'd3) ? V_WID[v] : 0;
            e_aon = (V_ACT[v] == 3'd4) ? V_WID[v] : 0;
            chk("R4", $sformatf("vec%0d expiry sample", v), rise, V_RISE[v]);
            chk("R9", $sformatf("vec%0d cpu width", v), n_cpu, e_cpu);
            chk("R9", $sformatf("vec%0d sys width", v), n_sys, e_sys);
            chk("R5", $sformatf("vec%0d aon width", v), n_aon, e_aon);
            chk("R10", $sformatf("vec%0d irq level", v), n_irq, e_irq);
            wr(3'd1, 32'd0);
            wr(3'd3, 32'd1);
            wait_cyc(3);
        end

        // R5: action codes 5..7 behave as off
        wr(3'd2, 32'd5);
        wr(3'd4, 32'd0);
        wr(3'd1, 32'h1);
        n_irq = 0; n_cpu = 0; n_sys = 0; n_aon = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            n_irq += irq; n_cpu += cpu_rst; n_sys += sys_rst; n_aon += aon_rst;
        end
        chk("R5", "code 5 outputs", n_irq + n_cpu + n_sys + n_aon, 0);
        rd(3'd3, r); chk("R5", "code 5 status", r, 0);
        wr(3'd1, 32'd0);

        // R6: escalation irq -> cpu -> sys, then wait at the stage whose action is off
        wr(3'd2, 32'h0D1);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd4);
        wr(3'd6, 32'd2);
        wr(3'd1, {24'd0, 3'd0, 3'd1, 2'b01});
        cfg_addr = 3'd3;
        wait_cyc(3);
        chk("R6", "irq before stage0 expiry", {31'd0, irq}, 0);
        wait_cyc(1);
        chk("R6", "irq at stage0 expiry", {31'd0, irq}, 1);
        chk("R6", "status stage1", cfg_rdata, 32'h3);
        wait_cyc(4);
        chk("R6", "cpu before stage1 expiry", {31'd0, cpu_rst}, 0);
        wait_cyc(1);
        chk("R6", "cpu at stage1 expiry", {31'd0, cpu_rst}, 1);
        wait_cyc(2);
        chk("R9", "cpu 2-cycle pulse ended", {31'd0, cpu_rst}, 0);
        wait_cyc(1);
        chk("R6", "sys at stage2 expiry", {31'd0, sys_rst}, 1);
        wait_cyc(28);
        chk("R6", "parked at stage3", cfg_rdata, 32'h7);
        chk("R6", "no later reset", {31'd0, cpu_rst | sys_rst | aon_rst}, 0);

        // R10: clear works while locked
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd1);
        chk("R10", "irq cleared while locked", {31'd0, irq}, 0);
        wr(3'd0, KEY);
        wr(3'd1, 32'd0);

        // R6: all four stages expire, then done
        wr(3'd2, 32'h492);
        wr(3'd4, 32'd0); wr(3'd5, 32'd0); wr(3'd6, 32'd0); wr(3'd7, 32'd0);
        wr(3'd1, 32'h1);
        cfg_addr = 3'd3;
        n_cpu = 0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            n_cpu += cpu_rst;
        end
        chk("R6", "four cpu expiries", n_cpu, 4);
        wait_cyc(2);
        chk("R6", "done after stage3", cfg_rdata, 32'hE);
        chk("R6", "cpu quiet when done", {31'd0, cpu_rst}, 0);

        // R7: feed from the done state returns to stage 0
        do_feed();
        #1 chk("R7", "status after feed", cfg_rdata & 32'h8, 0);
        wr(3'd1, 32'd0);

        // R7: feed just before expiry restarts the count
        wr(3'd2, 32'd1);
        wr(3'd4, 32'd10);
        wr(3'd1, 32'h1);
        wait_cyc(8);
        do_feed();
        wait_cyc(10);
        chk("R7", "irq held off by feed", {31'd0, irq}, 0);
        wait_cyc(1);
        chk("R7", "irq after full restart", {31'd0, irq}, 1);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd1);

        // R8: disable stops the timer
        wr(3'd4, 32'd5);
        wr(3'd1, 32'h1);
        wait_cyc(3);
        wr(3'd1, 32'd0);
        wait_cyc(10);
        chk("R8", "irq after disable", {31'd0, irq}, 0);
        rd(3'd3, r); chk("R8", "status after disable", r, 0);

        finish_run();
    end

endmodule